// File: doc/BRIEF.md
# Four-Channel Fault Capture and Latch-Off

This block sits between the analog fault comparators of a four-channel low-side driver and the serial diagnostic port. It turns raw per-channel comparator levels into sticky diagnostic flags, and it gates the enables of the four output drivers. A short-circuit comparator acts at once. It records the event and forces that driver off. The driver stays off until the channel's command input has gone low and then high again. The open-load and short-to-ground comparators only count as faults after they stay high for a filter window, so switching glitches are not recorded.

Several temperature sensor inputs are merged into one over-temperature flag. That flag never turns a driver off. A summary flag is the OR of every sticky bit, and the serial port can poll it. The serial port reads the flags and then pulses the clear input. A condition still present after the clear sets its flag again on the next cycle. The open-load filter length is chosen per channel by a configuration bit.

Top module: `quad_fault_latch`

## Requirements
- R1: After reset all flags are 0, the summary flag is 0, and each driver enable equals its command input.
- R2: A high short-circuit comparator sampled at a clock edge while the command is high sets that channel's short flag, and drives its enable low, from that edge on.
- R3: A latched-off channel stays disabled while its command stays high, and a clear does not re-enable it. After one edge that samples the command low, the enable follows the command again.
- R4: Any high temperature sensor input sets the single temperature flag at the next edge. The temperature flag never changes a driver enable.
- R5: The open-load flag sets at the edge after 16 consecutive edges of a high comparator when the channel's fast-select bit is 1, and after 64 when it is 0. One edge fewer leaves it clear.
- R6: A low comparator sample restarts the filter count, so 15 high edges, then one low edge, then 15 high edges leaves the flag clear.
- R7: The short-to-ground flag sets at the edge after 16 consecutive high comparator edges. After 15 it stays clear.
- R8: The summary flag is 1 exactly when any short, open-load, short-to-ground or temperature flag is 1.
- R9: A clear pulse sampled at an edge zeroes all flags at that edge. A condition still present sets its flag again at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 4 | Per-channel on command |
| sc_cmp | input | 4 | Short-circuit comparator levels |
| ol_cmp | input | 4 | Open-load comparator levels |
| sg_cmp | input | 4 | Short-to-ground comparator levels |
| temp_sns | input | 2 | Over-temperature sensor levels |
| ol_fast | input | 4 | Per-channel open-load delay select, 1 = short delay |
| diag_clr | input | 1 | Clear strobe from the serial port |
| drv_en | output | 4 | Driver enables |
| flag_sc | output | 4 | Sticky short-circuit flags |
| flag_ol | output | 4 | Sticky open-load flags |
| flag_sg | output | 4 | Sticky short-to-ground flags |
| flag_temp | output | 1 | Sticky over-temperature flag |
| flag_any | output | 1 | OR of all sticky flags |

## Verification
The filters are driven with comparator pulses of exactly the threshold length and of one edge less. This is done for both open-load delay settings and for the short-to-ground path, on different channels, so an off-by-one count or a swapped select shows up. A pattern of 15 high edges, one low edge and 15 more high edges separates a restarting counter from one that only holds. Directed sequences of short-circuit, clear, command toggle and temperature events check that the latch-off releases only through the command input, and that temperature and clear leave the enables alone.

// File: rtl/qfl_pkg.sv
package qfl_pkg;
   typedef struct packed {
      logic sc;
      logic ol;
      logic sg;
   } chan_flags_t;
endpackage

// File: rtl/qfl_filter.sv
module qfl_filter #(
   parameter int LIM_A = 16,
   parameter int LIM_B = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic sel_a,
   output logic qual
);
   localparam int LMAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
   localparam int CW   = $clog2(LMAX + 1);
   localparam logic [CW-1:0] LA = CW'(LIM_A);
   localparam logic [CW-1:0] LB = CW'(LIM_B);
   localparam logic [CW-1:0] LM = CW'(LMAX);

   generate
      if (LIM_A < 1 || LIM_B < 1) begin : g_bad_lim
         $error("qfl_filter: limits must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim  = sel_a ? LA : LB;
   assign qual = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!din)   cnt <= '0;
      else if (cnt != LM) cnt <= cnt + 1'b1;
   end

   // R5 / R6: a qualified level needs the comparator high on the previous edge
   assert_qual_needs_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && $past(rst_n)) |-> $past(din));
endmodule

// File: rtl/qfl_channel.sv
module qfl_channel
   import qfl_pkg::*;
#(
   parameter int OL_SHORT = 16,
   parameter int OL_LONG  = 64,
   parameter int SG_DLY   = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd,
   input  logic        sc_cmp,
   input  logic        ol_cmp,
   input  logic        sg_cmp,
   input  logic        ol_fast,
   input  logic        clr,
   output logic        drv_en,
   output chan_flags_t flags
);
   logic ol_q, sg_q, lock_q;

   qfl_filter #(.LIM_A(OL_SHORT), .LIM_B(OL_LONG)) u_ol (
      .clk(clk), .rst_n(rst_n), .din(ol_cmp), .sel_a(ol_fast), .qual(ol_q));

   qfl_filter #(.LIM_A(SG_DLY), .LIM_B(SG_DLY)) u_sg (
      .clk(clk), .rst_n(rst_n), .din(sg_cmp), .sel_a(1'b1), .qual(sg_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lock_q <= 1'b0;
      else if (!cmd)     lock_q <= 1'b0;
      else if (sc_cmp)   lock_q <= 1'b1;
   end

   assign drv_en = cmd & ~lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else if (clr) begin
         flags <= '0;
      end else begin
         flags.sc <= flags.sc | sc_cmp;
         flags.ol <= flags.ol | ol_q;
         flags.sg <= flags.sg | sg_q;
      end
   end

   assert_short_disables_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_cmp && cmd) |=> (!drv_en && flags.sc));
   assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && cmd) |=> lock_q);
   assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flags == '0));
   assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.ol && !clr) |=> flags.ol);
endmodule

// File: rtl/quad_fault_latch.sv
module quad_fault_latch
   import qfl_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int NTEMP    = 2,
   parameter int OL_SHORT = 16,
   parameter int OL_LONG  = 64,
   parameter int SG_DLY   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   cmd_in,
   input  logic [NCH-1:0]   sc_cmp,
   input  logic [NCH-1:0]   ol_cmp,
   input  logic [NCH-1:0]   sg_cmp,
   input  logic [NTEMP-1:0] temp_sns,
   input  logic [NCH-1:0]   ol_fast,
   input  logic             diag_clr,
   output logic [NCH-1:0]   drv_en,
   output logic [NCH-1:0]   flag_sc,
   output logic [NCH-1:0]   flag_ol,
   output logic [NCH-1:0]   flag_sg,
   output logic             flag_temp,
   output logic             flag_any
);
   generate
      if (NCH < 1 || NTEMP < 1) begin : g_bad_count
         $error("quad_fault_latch: NCH and NTEMP must be at least 1");
      end
      if (OL_SHORT >= OL_LONG) begin : g_bad_order
         $error("quad_fault_latch: OL_SHORT must be below OL_LONG");
      end
   endgenerate

   chan_flags_t ch_flags [NCH];

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         qfl_channel #(.OL_SHORT(OL_SHORT), .OL_LONG(OL_LONG), .SG_DLY(SG_DLY)) u_ch (
            .clk(clk), .rst_n(rst_n), .cmd(cmd_in[c]), .sc_cmp(sc_cmp[c]),
            .ol_cmp(ol_cmp[c]), .sg_cmp(sg_cmp[c]), .ol_fast(ol_fast[c]),
            .clr(diag_clr), .drv_en(drv_en[c]), .flags(ch_flags[c]));
         assign flag_sc[c] = ch_flags[c].sc;
         assign flag_ol[c] = ch_flags[c].ol;
         assign flag_sg[c] = ch_flags[c].sg;
      end
   endgenerate

   logic hot;
   assign hot = |temp_sns;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_temp <= 1'b0;
      else if (diag_clr) flag_temp <= 1'b0;
      else if (hot)      flag_temp <= 1'b1;
   end

   assign flag_any = flag_temp | (|flag_sc) | (|flag_ol) | (|flag_sg);

   assert_temp_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_temp && !diag_clr) |=> flag_temp);
   assert_temp_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hot && !diag_clr) |=> flag_temp);
   assert_any_covers_temp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_temp |-> flag_any);
endmodule

// File: tb/quad_fault_latch_test.sv
`timescale 1ns/1ps
module quad_fault_latch_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cmd_in = '0, sc_cmp = '0, ol_cmp = '0, sg_cmp = '0, ol_fast = '0;
   logic [1:0] temp_sns = '0;
   logic       diag_clr = 1'b0;
   logic [3:0] drv_en, flag_sc, flag_ol, flag_sg;
   logic       flag_temp, flag_any;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   quad_fault_latch uut (.*);

   // {sg_kind, channel[1:0], fast, high_edges[6:0], expected}
   localparam logic [11:0] VEC [0:7] = '{
      {1'b0, 2'd0, 1'b1, 7'd16, 1'b1},   // R5 fast, exact
      {1'b0, 2'd1, 1'b1, 7'd15, 1'b0},   // R5 fast, one short
      {1'b0, 2'd2, 1'b0, 7'd64, 1'b1},   // R5 slow, exact
      {1'b0, 2'd3, 1'b0, 7'd63, 1'b0},   // R5 slow, one short
      {1'b0, 2'd3, 1'b0, 7'd16, 1'b0},   // R5 slow select ignores short window
      {1'b1, 2'd1, 1'b0, 7'd16, 1'b1},   // R7 exact
      {1'b1, 2'd2, 1'b1, 7'd15, 1'b0},   // R7 one short
      {1'b1, 2'd0, 1'b0, 7'd40, 1'b1}    // R7 long pulse
   };

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic pulse_clr();
      diag_clr = 1'b1;
      step(1);
      diag_clr = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [11:0] v;
      cmd_in = 4'b1010;
      step(2);
      rst_n = 1'b1;
      step(1);
      chk("R1 enables", drv_en, 4'b1010);
      chk("R1 flags", flag_sc | flag_ol | flag_sg, 4'b0000);
      chk("R1 any", {3'b0, flag_any}, 4'b0000);

      // filter table
      for (int i = 0; i < 8; i++) begin
         v = VEC[i];
         ol_fast = {4{v[8]}};
         if (v[11]) sg_cmp[v[10:9]] = 1'b1; else ol_cmp[v[10:9]] = 1'b1;
         step(int'(v[7:1]));
         sg_cmp = '0; ol_cmp = '0;
         step(1);
         if (v[11]) chk($sformatf("R7 vec%0d", i), flag_sg, v[0] ? (4'b1 << v[10:9]) : 4'b0);
         else       chk($sformatf("R5 vec%0d", i), flag_ol, v[0] ? (4'b1 << v[10:9]) : 4'b0);
         chk($sformatf("R8 vec%0d", i), {3'b0, flag_any}, {3'b0, v[0]});
         pulse_clr();
      end

      // R6: low sample restarts the count
      ol_fast = 4'b1111;
      ol_cmp[1] = 1'b1; step(15);
      ol_cmp[1] = 1'b0; step(1);
      ol_cmp[1] = 1'b1; step(15);
      ol_cmp[1] = 1'b0; step(1);
      chk("R6 restart", flag_ol, 4'b0000);

      // R2 / R3 short-circuit latch-off
      cmd_in = 4'b1111;
      step(1);
      sc_cmp[2] = 1'b1; step(1); sc_cmp[2] = 1'b0;
      chk("R2 flag", flag_sc, 4'b0100);
      chk("R2 enable", drv_en, 4'b1011);
      chk("R8 short", {3'b0, flag_any}, 4'b0001);
      step(3);
      chk("R3 held", drv_en, 4'b1011);
      pulse_clr();
      chk("R9 clear", flag_sc, 4'b0000);
      chk("R3 clear keeps off", drv_en, 4'b1011);
      cmd_in[2] = 1'b0; step(1);
      chk("R3 low", drv_en, 4'b1011);
      cmd_in[2] = 1'b1; step(1);
      chk("R3 reenable", drv_en, 4'b1111);

      // R4 temperature
      temp_sns = 2'b10; step(1); temp_sns = 2'b00;
      chk("R4 flag", {3'b0, flag_temp}, 4'b0001);
      chk("R4 enables", drv_en, 4'b1111);
      chk("R8 temp", {3'b0, flag_any}, 4'b0001);
      pulse_clr();
      chk("R9 temp clear", {3'b0, flag_temp}, 4'b0000);

      // R9 persisting condition re-sets
      temp_sns = 2'b01;
      step(1);
      diag_clr = 1'b1; step(1); diag_clr = 1'b0;
      chk("R9 cleared", {3'b0, flag_temp}, 4'b0000);
      step(1);
      chk("R9 re-set", {3'b0, flag_temp}, 4'b0001);
      temp_sns = 2'b00;
      pulse_clr();
      chk("R8 idle", {3'b0, flag_any}, 4'b0000);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule